// File: doc/BRIEF.md
# Display Controller Indexed Register File

This block is the indexed register bank of a display controller, reached through a byte-wide port pair: an index port picks one of 128 eight-bit registers, and a data port reads or writes the register picked. The port pair sits at a colour base address. When the host selects monochrome addressing, the block shifts its decoding so that the same registers answer at the monochrome base instead.

Beside the plain storage, the block guards the legacy horizontal and vertical timing registers with a protect bit. It also turns a handful of extended registers into live side outputs for the rest of the display pipe: read and write bank byte offsets for the memory aperture, the mode nibble of an indirect register window, pixel depth, and the high bits that widen the timing counters. A one-cycle strobe tells the timing generator when its settings must be recomputed. The timing generator itself lives outside this block.

Top module: `crtc_ext_regs`

## Requirements
- R1: After reset, every register, the index, the read data, all side outputs and the recompute strobe are zero.
- R2: A write to the index port (0x3D4 after remapping) stores bits 6:0 of the byte. Reading the index port returns that value with bit 7 clear.
- R3: While bit 7 of register 0x11 is set, data writes to indices 0 to 6 leave the register unchanged and raise no strobe. A data write to index 7 changes only bit 4.
- R4: The read bank is register 0x1E bits 7:1 and the write bank is register 0x1D bits 7:1. Each bank byte offset is the bank shifted left by 16 when chain4_mode is high, and by 14 otherwise.
- R5: win_mode equals bits 3:0 of register 0x38.
- R6: Bits of register 0x25 drive the timing high bits. Bit 0 drives vert_bit10[0] (vertical total bit 10), bit 1 drives vert_bit10[1] (display end), bit 2 drives vert_bit10[2] (blank start), bit 3 drives vert_bit10[3] (sync start). Bit 4 drives htot_bit8 (horizontal total bit 8). Bit 5 drives row_off_hi[3] (row offset bit 11).
- R7: Register 0x19 bits 4:0 drive start_addr_hi (start address bits 20:16). Its bits 7:5 drive row_off_hi[2:0] (row offset bits 10:8).
- R8: depth_code equals register 0x28 bits 1:0. bits_per_pixel is 8, 16 or 32 for codes 1, 2 and 3, and 0 for code 0.
- R9: timing_recalc is high for exactly the cycle after an accepted data write when either of these holds: the value changed and the index lies outside 0x0E to 0x10, or the index is 0x19, 0x25 or 0x28, whatever the value.
- R10: While misc_color_sel is low, any address whose bits 15:4 equal 0x3D0 or 0x3B0 is XORed with 0x60 before decoding. The data port is 0x3D5 after remapping. Any other address changes nothing and reads as 0.
- R11: io_rdata updates on the clock edge that samples io_rd and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write byte |
| misc_color_sel | input | 1 | Miscellaneous-output bit 0: 1 selects colour addressing |
| chain4_mode | input | 1 | Chain-4 memory mode, selects the bank shift |
| io_rdata | output | 8 | Registered read byte |
| rd_bank_off | output | 23 | Read bank byte offset |
| wr_bank_off | output | 23 | Write bank byte offset |
| win_mode | output | 4 | Indirect window mode nibble |
| depth_code | output | 2 | Pixel depth code |
| bits_per_pixel | output | 6 | Decoded pixel depth |
| start_addr_hi | output | 5 | Start address bits 20:16 |
| row_off_hi | output | 4 | Row offset bits 11:8 |
| vert_bit10 | output | 4 | Bit 10 of vtotal, display end, blank start, sync start |
| htot_bit8 | output | 1 | Horizontal total bit 8 |
| timing_recalc | output | 1 | One-cycle timing recompute strobe |

## Verification
The main path is exercised with a changed value, an unchanged rewrite, a write inside the excluded 0x0E–0x10 window, and a repeated write to a forced index. Together these separate the change rule from the forced-index rule of the strobe. Protection is probed on a low index, on index 7 with all bits set, and again after unlocking, which tells the full lock apart from the single-bit pass. The bank offsets are read under both chain4_mode values with both a small bank and an all-ones bank, so a wrong shift or a dropped bit shows up. Address remapping is tried under both addressing modes: the moved address must answer, and the unmoved address must be ignored in both directions.

// File: rtl/crtc_ext_pkg.sv
package crtc_ext_pkg;

    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_INDEX = 2'd1,
        PK_DATA  = 2'd2
    } port_kind_e;

    localparam logic [6:0] IX_PROTECT   = 7'h11;
    localparam logic [6:0] IX_ADDR_EXT  = 7'h19;
    localparam logic [6:0] IX_WR_BANK   = 7'h1D;
    localparam logic [6:0] IX_RD_BANK   = 7'h1E;
    localparam logic [6:0] IX_OVERFLOW  = 7'h25;
    localparam logic [6:0] IX_DEPTH     = 7'h28;
    localparam logic [6:0] IX_WINDOW    = 7'h38;
    localparam logic [6:0] IX_HALF_LOCK = 7'h07;
    localparam logic [6:0] IX_QUIET_LO  = 7'h0E;
    localparam logic [6:0] IX_QUIET_HI  = 7'h10;

endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode
    import crtc_ext_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] COLOR_BASE = 16'h03D0,
    parameter logic [ADDR_W-1:0] MONO_BASE  = 16'h03B0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              color_sel,
    output port_kind_e        kind
);
    localparam logic [ADDR_W-1:0] SWAP_MASK  = COLOR_BASE ^ MONO_BASE;
    localparam logic [ADDR_W-1:0] RANGE_MASK = ~ADDR_W'(15);
    localparam logic [ADDR_W-1:0] IDX_PORT   = COLOR_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] DAT_PORT   = COLOR_BASE + ADDR_W'(5);

    logic              in_range;
    logic [ADDR_W-1:0] eff_addr;

    always_comb begin
        in_range = ((addr & RANGE_MASK) == COLOR_BASE) ||
                   ((addr & RANGE_MASK) == MONO_BASE);
        eff_addr = (in_range && !color_sel) ? (addr ^ SWAP_MASK) : addr;
        if (eff_addr == IDX_PORT)      kind = PK_INDEX;
        else if (eff_addr == DAT_PORT) kind = PK_DATA;
        else                           kind = PK_NONE;
    end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_ext_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 7,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [DATA_W-1:0] cur_val,
    output logic              lock,
    output logic              commit,
    output logic              changed,
    output logic [DATA_W-1:0] r_addr_ext,
    output logic [DATA_W-1:0] r_wr_bank,
    output logic [DATA_W-1:0] r_rd_bank,
    output logic [DATA_W-1:0] r_overflow,
    output logic [DATA_W-1:0] r_depth,
    output logic [DATA_W-1:0] r_window
);
    logic [DATA_W-1:0] regs [DEPTH];
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] next_val;
    logic              low_locked;

    assign cur_idx = idx_q;
    assign cur_val = regs[idx_q];
    assign lock    = regs[IX_PROTECT][DATA_W-1];

    always_comb begin
        low_locked = lock && (idx_q < IX_HALF_LOCK);
        next_val   = wdata;
        if (lock && (idx_q == IX_HALF_LOCK))
            next_val = (cur_val & ~DATA_W'(8'h10)) | (wdata & DATA_W'(8'h10));
        commit  = data_wr && !low_locked;
        changed = (next_val != cur_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            if (idx_wr) idx_q <= wdata[IDX_W-1:0];
            if (commit) regs[idx_q] <= next_val;
        end
    end

    assign r_addr_ext = regs[IX_ADDR_EXT];
    assign r_wr_bank  = regs[IX_WR_BANK];
    assign r_rd_bank  = regs[IX_RD_BANK];
    assign r_overflow = regs[IX_OVERFLOW];
    assign r_depth    = regs[IX_DEPTH];
    assign r_window   = regs[IX_WINDOW];
endmodule

// File: rtl/crtc_side_out.sv
module crtc_side_out #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CHAIN_SHIFT = 16,
    parameter int unsigned PLANE_SHIFT = 14,
    localparam int unsigned BANK_W = DATA_W - 1,
    localparam int unsigned OFF_W  = BANK_W + CHAIN_SHIFT
) (
    input  logic              chain4,
    input  logic [DATA_W-1:0] r_addr_ext,
    input  logic [DATA_W-1:0] r_wr_bank,
    input  logic [DATA_W-1:0] r_rd_bank,
    input  logic [DATA_W-1:0] r_overflow,
    input  logic [DATA_W-1:0] r_depth,
    input  logic [DATA_W-1:0] r_window,
    output logic [OFF_W-1:0]  rd_off,
    output logic [OFF_W-1:0]  wr_off,
    output logic [3:0]        win_mode,
    output logic [1:0]        depth_code,
    output logic [5:0]        bpp,
    output logic [4:0]        start_hi,
    output logic [3:0]        row_hi,
    output logic [3:0]        vert_b10,
    output logic              htot_b8
);
    logic [BANK_W-1:0] bank_sel [2];
    logic [OFF_W-1:0]  off_out  [2];

    assign bank_sel[0] = r_rd_bank[DATA_W-1:1];
    assign bank_sel[1] = r_wr_bank[DATA_W-1:1];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_comb begin
            if (chain4) off_out[g] = OFF_W'(bank_sel[g]) << CHAIN_SHIFT;
            else        off_out[g] = OFF_W'(bank_sel[g]) << PLANE_SHIFT;
        end
    end

    assign rd_off = off_out[0];
    assign wr_off = off_out[1];

    always_comb begin
        win_mode   = r_window[3:0];
        depth_code = r_depth[1:0];
        unique case (r_depth[1:0])
            2'd1:    bpp = 6'd8;
            2'd2:    bpp = 6'd16;
            2'd3:    bpp = 6'd32;
            default: bpp = 6'd0;
        endcase
        start_hi = r_addr_ext[4:0];
        row_hi   = {r_overflow[5], r_addr_ext[7:5]};
        vert_b10 = r_overflow[3:0];
        htot_b8  = r_overflow[4];
    end
endmodule

// File: rtl/crtc_ext_regs.sv
module crtc_ext_regs
    import crtc_ext_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned IDX_W       = 7,
    parameter int unsigned CHAIN_SHIFT = 16,
    parameter int unsigned PLANE_SHIFT = 14,
    localparam int unsigned OFF_W      = DATA_W - 1 + CHAIN_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              misc_color_sel,
    input  logic              chain4_mode,
    output logic [DATA_W-1:0] io_rdata,
    output logic [OFF_W-1:0]  rd_bank_off,
    output logic [OFF_W-1:0]  wr_bank_off,
    output logic [3:0]        win_mode,
    output logic [1:0]        depth_code,
    output logic [5:0]        bits_per_pixel,
    output logic [4:0]        start_addr_hi,
    output logic [3:0]        row_off_hi,
    output logic [3:0]        vert_bit10,
    output logic              htot_bit8,
    output logic              timing_recalc
);
    port_kind_e        kind;
    logic              idx_wr, data_wr;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] cur_val;
    logic              lock_bit, commit, changed;
    logic [DATA_W-1:0] r_addr_ext, r_wr_bank, r_rd_bank, r_overflow, r_depth, r_window;
    logic              forced_idx, quiet_idx, recalc_d;

    crtc_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (io_addr),
        .color_sel (misc_color_sel),
        .kind      (kind)
    );

    assign idx_wr  = io_wr && (kind == PK_INDEX);
    assign data_wr = io_wr && (kind == PK_DATA);

    crtc_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .data_wr    (data_wr),
        .wdata      (io_wdata),
        .cur_idx    (cur_idx),
        .cur_val    (cur_val),
        .lock       (lock_bit),
        .commit     (commit),
        .changed    (changed),
        .r_addr_ext (r_addr_ext),
        .r_wr_bank  (r_wr_bank),
        .r_rd_bank  (r_rd_bank),
        .r_overflow (r_overflow),
        .r_depth    (r_depth),
        .r_window   (r_window)
    );

    crtc_side_out #(
        .DATA_W(DATA_W), .CHAIN_SHIFT(CHAIN_SHIFT), .PLANE_SHIFT(PLANE_SHIFT)
    ) u_side (
        .chain4     (chain4_mode),
        .r_addr_ext (r_addr_ext),
        .r_wr_bank  (r_wr_bank),
        .r_rd_bank  (r_rd_bank),
        .r_overflow (r_overflow),
        .r_depth    (r_depth),
        .r_window   (r_window),
        .rd_off     (rd_bank_off),
        .wr_off     (wr_bank_off),
        .win_mode   (win_mode),
        .depth_code (depth_code),
        .bpp        (bits_per_pixel),
        .start_hi   (start_addr_hi),
        .row_hi     (row_off_hi),
        .vert_b10   (vert_bit10),
        .htot_b8    (htot_bit8)
    );

    always_comb begin
        forced_idx = (cur_idx == IX_ADDR_EXT) || (cur_idx == IX_OVERFLOW) ||
                     (cur_idx == IX_DEPTH);
        quiet_idx  = (cur_idx >= IX_QUIET_LO) && (cur_idx <= IX_QUIET_HI);
        recalc_d   = commit && (forced_idx || (changed && !quiet_idx));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_recalc <= 1'b0;
            io_rdata      <= '0;
        end else begin
            timing_recalc <= recalc_d;
            if (io_rd) begin
                unique case (kind)
                    PK_INDEX: io_rdata <= DATA_W'(cur_idx);
                    PK_DATA:  io_rdata <= cur_val;
                    default:  io_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/crtc_ext_regs_chk.sv
module crtc_ext_regs_chk #(
    parameter int unsigned OFF_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idx_wr,
    input logic             data_wr,
    input logic [7:0]       wdata,
    input logic [6:0]       cur_idx,
    input logic             lock_bit,
    input logic             chain4,
    input logic             recalc,
    input logic [OFF_W-1:0] rd_off,
    input logic [3:0]       win_mode,
    input logic [5:0]       bpp
);
    // R2
    a_r2_index_low7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (cur_idx == $past(wdata[6:0])));

    // R3
    a_r3_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && lock_bit && (cur_idx < 7'd7)) |=> !recalc);

    // R4
    a_r4_offset_align: assert property (@(posedge clk) disable iff (!rst_n)
        chain4 |-> (rd_off[15:0] == 16'd0));

    // R4
    a_r4_offset_top: assert property (@(posedge clk) disable iff (!rst_n)
        !chain4 |-> (rd_off[OFF_W-1:OFF_W-2] == 2'd0));

    // R5
    a_r5_window_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && (cur_idx == 7'h38)) |=> (win_mode == $past(wdata[3:0])));

    // R8
    a_r8_depth_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bpp));

    // R9
    a_r9_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        recalc |-> $past(data_wr));
endmodule

bind crtc_ext_regs crtc_ext_regs_chk #(.OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .data_wr  (data_wr),
    .wdata    (io_wdata),
    .cur_idx  (cur_idx),
    .lock_bit (lock_bit),
    .chain4   (chain4_mode),
    .recalc   (timing_recalc),
    .rd_off   (rd_bank_off),
    .win_mode (win_mode),
    .bpp      (bits_per_pixel)
);

// File: tb/tb_crtc_ext_regs.sv
module tb_crtc_ext_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        misc_color_sel = 1'b1, chain4_mode = 1'b0;
    logic [7:0]  io_rdata;
    logic [22:0] rd_bank_off, wr_bank_off;
    logic [3:0]  win_mode, row_off_hi, vert_bit10;
    logic [1:0]  depth_code;
    logic [5:0]  bits_per_pixel;
    logic [4:0]  start_addr_hi;
    logic        htot_bit8, timing_recalc;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    bit         done = 0;

    localparam logic [15:0] CI = 16'h03D4, CD = 16'h03D5;
    localparam logic [15:0] MI = 16'h03B4, MD = 16'h03B5;

    always #10 clk = ~clk;

    crtc_ext_regs dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .misc_color_sel(misc_color_sel), .chain4_mode(chain4_mode),
        .io_rdata(io_rdata), .rd_bank_off(rd_bank_off), .wr_bank_off(wr_bank_off),
        .win_mode(win_mode), .depth_code(depth_code), .bits_per_pixel(bits_per_pixel),
        .start_addr_hi(start_addr_hi), .row_off_hi(row_off_hi), .vert_bit10(vert_bit10),
        .htot_bit8(htot_bit8), .timing_recalc(timing_recalc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] ix, input logic [7:0] d);
        wr(CI, ix);
        wr(CD, d);
    endtask

    task automatic rd_exp(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= io_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk("R11 unexpected read", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), 32'(io_rdata), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", 32'(io_rdata), 0);
        chk("R1 recalc", 32'(timing_recalc), 0);
        chk("R1 offsets", 32'(rd_bank_off | wr_bank_off), 0);
        chk("R1 side", 32'({win_mode, bits_per_pixel, start_addr_hi, row_off_hi, vert_bit10, htot_bit8}), 0);
        rd_exp(CD, 8'h00, "R1 reg0");

        // R2 index keeps low 7 bits
        wr(CI, 8'hC5);
        rd_exp(CI, 8'h45, "R2 index");

        // R9 strobe on change, not on same value, not in quiet window
        set_reg(8'h00, 8'h5A);
        chk("R9 change pulse", 32'(timing_recalc), 1);
        @(negedge clk);
        chk("R9 one cycle", 32'(timing_recalc), 0);
        rd_exp(CD, 8'h5A, "R11 reg0 readback");
        wr(CD, 8'h5A);
        chk("R9 same value quiet", 32'(timing_recalc), 0);
        set_reg(8'h0F, 8'h33);
        chk("R9 quiet window", 32'(timing_recalc), 0);
        rd_exp(CD, 8'h33, "R9 quiet stored");

        // R7 / R9 forced index
        set_reg(8'h19, 8'hE3);
        chk("R9 forced 19", 32'(timing_recalc), 1);
        wr(CD, 8'hE3);
        chk("R9 forced same", 32'(timing_recalc), 1);
        chk("R7 start hi", 32'(start_addr_hi), 32'h03);
        chk("R7 row bits", 32'(row_off_hi), 32'h7);

        // R6
        set_reg(8'h25, 8'h3F);
        chk("R6 vert", 32'(vert_bit10), 32'hF);
        chk("R6 htot", 32'(htot_bit8), 1);
        chk("R6 row11", 32'(row_off_hi), 32'hF);
        wr(CD, 8'h15);
        chk("R6 vert b", 32'(vert_bit10), 32'h5);
        chk("R6 row b", 32'(row_off_hi), 32'h7);
        chk("R6 htot b", 32'(htot_bit8), 1);

        // R3 protection
        set_reg(8'h11, 8'h80);
        set_reg(8'h00, 8'h11);
        chk("R3 locked no pulse", 32'(timing_recalc), 0);
        rd_exp(CD, 8'h5A, "R3 locked reg0");
        set_reg(8'h07, 8'hFF);
        rd_exp(CD, 8'h10, "R3 index7 bit4");
        set_reg(8'h11, 8'h00);
        set_reg(8'h00, 8'h11);
        rd_exp(CD, 8'h11, "R3 unlocked reg0");

        // R4 banks
        set_reg(8'h1E, 8'h0B);
        set_reg(8'h1D, 8'hFF);
        chk("R4 rd planar", 32'(rd_bank_off), 32'h14000);
        chk("R4 wr planar", 32'(wr_bank_off), 32'h1FC000);
        chain4_mode = 1'b1;
        @(negedge clk);
        chk("R4 rd chain", 32'(rd_bank_off), 32'h50000);
        chk("R4 wr chain", 32'(wr_bank_off), 32'h7F0000);

        // R5
        set_reg(8'h38, 8'hA7);
        chk("R5 window", 32'(win_mode), 32'h7);

        // R8
        set_reg(8'h28, 8'hFD);
        chk("R8 code1", 32'({depth_code, bits_per_pixel}), 32'({2'd1, 6'd8}));
        wr(CD, 8'h02);
        chk("R8 code2", 32'(bits_per_pixel), 16);
        wr(CD, 8'h03);
        chk("R8 code3", 32'(bits_per_pixel), 32);
        wr(CD, 8'h00);
        chk("R8 code0", 32'(bits_per_pixel), 0);

        // R10 remap
        misc_color_sel = 1'b0;
        wr(MI, 8'h38);
        rd_exp(MD, 8'hA7, "R10 mono data");
        wr(CI, 8'h00);
        rd_exp(MI, 8'h38, "R10 colour idx ignored in mono");
        rd_exp(CD, 8'h00, "R10 unmapped reads zero");
        misc_color_sel = 1'b1;
        wr(MI, 8'h05);
        rd_exp(CI, 8'h38, "R10 mono idx ignored in colour");
        rd_exp(16'h03C0, 8'h00, "R10 foreign address");

        repeat (3) @(negedge clk);
        chk("R11 queue drained", 32'(exp_q.size()), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule